// File: doc/BRIEF.md
# Four-Channel TDM Serial Port with Chained Frame Pulse

This block is a slave port on a synchronous time-division serial bus. Each 125 µs frame holds 256 bit cells at 2048 kbit/s, grouped into 32 eight-bit channels. A frame pulse and a clock at twice the bit rate (4096 kHz) come from outside. The port owns the first four channels after its own frame pulse. During those channels it shifts out a 32-bit transmit word and shifts in a 32-bit receive word. Outside them it releases the line.

The port also regenerates a frame pulse delayed by exactly four channels. A second identical port that takes this pulse as its frame reference therefore owns channels 4 to 7, a third owns 8 to 11, and so on. No channel-assignment logic is needed. Each clock period is half a bit cell. The output launches on falling edges. The input is sampled on the rising edge three quarters of the way through a cell.

Top module: `tdm_chain_port`

## Requirements
- R1: After reset, and until the first frame pulse, the port keeps txOe low, txd high, frameOutN high, frameDone low and rxData at zero.
- R2: When frameInN is seen low at a rising clock edge, the next falling edge starts bit cell 0 (channel 0, bit 7). Every bit cell lasts two clock periods.
- R3: In cell c (0 to 31), txd carries transmit bit 31−c, so channel 0 comes from txData[31:24] and each byte is sent most significant bit first. txd changes only on the falling edge that starts a cell and holds for the whole cell.
- R4: txData is captured on the falling edge that starts cell 0. Changes to txData during the frame do not affect the bits sent in that frame.
- R5: txOe is high during cells 0 to 31 and low for the rest of the frame. While txOe is low, txd is driven high.
- R6: rxd is sampled on the second rising edge of each cell 0 to 31, and the first sample lands in rxData[31]. Samples from cells 32 to 255 are ignored.
- R7: rxData updates, and frameDone is high for exactly one clock period, at the rising edge that takes the last sample of cell 31. At all other edges rxData holds its value.
- R8: frameOutN goes low for one clock period, starting at the falling edge that opens the second half of cell 31. This is exactly 32 bit cells after the input pulse's low period.
- R9: If a frame pulse is missing, the cell counter wraps after 512 clock periods and the next frame runs as normal, including the capture of txData.
- R10: A frame pulse that arrives mid-frame realigns the port at once, and the following frame follows R2 to R8 from the new boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate bit clock (4096 kHz nominal) |
| rstN | input | 1 | Asynchronous reset, active low |
| frameInN | input | 1 | Frame pulse, active low, one clock period wide |
| rxd | input | 1 | Serial receive stream |
| txData | input | 32 | Transmit word; channel 0 in bits 31:24 |
| txd | output | 1 | Serial transmit stream |
| txOe | output | 1 | Line drive enable for txd |
| rxData | output | 32 | Received word; channel 0 in bits 31:24 |
| frameDone | output | 1 | One-clock strobe when rxData has updated |
| frameOutN | output | 1 | Delayed frame pulse for the next port in the chain |

## Verification
The assertions assume that frameInN is low for no more than one clock period at a time, and that rxd and frameInN only change between a falling edge and the next rising edge. The bench meets this by changing every input a short time after a falling edge. It drives the frame pulse only in the final clock period of a frame, or of a deliberately shortened one. Transmit and receive words are random from a fixed seed, with all-zero, all-one and alternating patterns directed first. Random values are also fed into rxd outside the owned channels and into txData in the middle of frames.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

  localparam int CELL_IDX_W = 8;

  typedef struct packed {
    logic                  txLoad;
    logic                  txLaunch;
    logic                  txIdle;
    logic [CELL_IDX_W-1:0] txIdx;
    logic                  rxSample;
    logic                  rxLast;
  } port_strobes_t;

endpackage

// File: rtl/tdm_port_ctrl.sv
module tdm_port_ctrl
  import tdm_port_pkg::*;
#(
  parameter int CHANNELS_PER_FRAME = 32,
  parameter int BITS_PER_CHANNEL   = 8,
  parameter int OWNED_CHANNELS     = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameInN,
  output port_strobes_t st,
  output logic          frameOutN
);

  localparam int CELLS_PER_FRAME = CHANNELS_PER_FRAME * BITS_PER_CHANNEL;
  localparam int CLKS_PER_FRAME  = CELLS_PER_FRAME * 2;
  localparam int CNT_W           = $clog2(CLKS_PER_FRAME);
  localparam int OWNED_CLKS      = OWNED_CHANNELS * BITS_PER_CHANNEL * 2;
  localparam int DELAY_POS       = OWNED_CLKS - 1;

  logic             frameSeen;
  logic             synced;
  logic             syncNext;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] nxtCnt;

  // Frame pulse is sampled on the rising edge, mid clock period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameSeen <= 1'b0;
    else       frameSeen <= !frameInN;
  end

  always_comb begin
    if (frameSeen)                                nxtCnt = '0;
    else if (halfCnt == CNT_W'(CLKS_PER_FRAME-1)) nxtCnt = '0;
    else                                          nxtCnt = halfCnt + 1'b1;
    syncNext = synced | frameSeen;
  end

  // Half-cell counter advances on falling edges; even values open a cell.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt   <= '0;
      synced    <= 1'b0;
      frameOutN <= 1'b1;
    end else begin
      halfCnt   <= nxtCnt;
      synced    <= syncNext;
      frameOutN <= !(syncNext && (nxtCnt == CNT_W'(DELAY_POS)));
    end
  end

  always_comb begin
    st.txLoad   = syncNext && (nxtCnt == '0);
    st.txLaunch = syncNext && !nxtCnt[0] && (nxtCnt < CNT_W'(OWNED_CLKS));
    st.txIdle   = !nxtCnt[0] && !st.txLaunch;
    st.txIdx    = CELL_IDX_W'(nxtCnt >> 1);
    st.rxSample = synced && halfCnt[0] && (halfCnt < CNT_W'(OWNED_CLKS));
    st.rxLast   = st.rxSample && (halfCnt == CNT_W'(OWNED_CLKS-1));
  end

  // R8: the chained pulse is a single clock period wide.
  p_frame_out_width_r8: assert property (@(negedge clk) disable iff (!rstN)
    !frameOutN |=> frameOutN);

  // R2: a seen frame pulse restarts the count at cell 0.
  p_restart_r2: assert property (@(negedge clk) disable iff (!rstN)
    frameSeen |=> (halfCnt == '0) && synced);

endmodule

// File: rtl/tdm_port_datapath.sv
module tdm_port_datapath
  import tdm_port_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  port_strobes_t     st,
  input  logic              rxd,
  input  logic [WORD_W-1:0] txData,
  output logic              txd,
  output logic              txOe,
  output logic [WORD_W-1:0] rxData,
  output logic              frameDone
);

  logic [WORD_W-1:0] txLatch;
  logic [WORD_W-1:0] txSrc;
  logic [WORD_W-1:0] txShifted;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] rxNext;

  always_comb begin
    txSrc     = st.txLoad ? txData : txLatch;
    txShifted = txSrc << st.txIdx;
    rxNext    = {rxShift[WORD_W-2:0], rxd};
  end

  // Transmit side: falling-edge launch at the start of a cell.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      txLatch <= '0;
      txd     <= 1'b1;
      txOe    <= 1'b0;
    end else begin
      if (st.txLoad) txLatch <= txData;
      if (st.txLaunch) begin
        txd  <= txShifted[WORD_W-1];
        txOe <= 1'b1;
      end else if (st.txIdle) begin
        txd  <= 1'b1;
        txOe <= 1'b0;
      end
    end
  end

  // Receive side: rising-edge sample at three quarters of the cell.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      rxData    <= '0;
      frameDone <= 1'b0;
    end else begin
      if (st.rxSample) rxShift <= rxNext;
      if (st.rxLast)   rxData  <= rxNext;
      frameDone <= st.rxLast;
    end
  end

  // R3: no change on the falling edge in the middle of a cell.
  p_mid_cell_hold_r3: assert property (@(negedge clk) disable iff (!rstN)
    !(st.txLaunch || st.txIdle) |=> $stable(txd));

  // R5: released line idles high.
  p_idle_high_r5: assert property (@(negedge clk) disable iff (!rstN)
    !txOe |-> txd);

  // R7: strobe lasts one clock.
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7: received word only moves together with the strobe.
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !frameDone |-> $stable(rxData));

endmodule

// File: rtl/tdm_chain_port.sv
module tdm_chain_port
  import tdm_port_pkg::*;
#(
  parameter int CHANNELS_PER_FRAME = 32,
  parameter int BITS_PER_CHANNEL   = 8,
  parameter int OWNED_CHANNELS     = 4,
  localparam int WORD_W            = OWNED_CHANNELS * BITS_PER_CHANNEL
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameInN,
  input  logic              rxd,
  input  logic [WORD_W-1:0] txData,
  output logic              txd,
  output logic              txOe,
  output logic [WORD_W-1:0] rxData,
  output logic              frameDone,
  output logic              frameOutN
);

  port_strobes_t strobes;

  tdm_port_ctrl #(
    .CHANNELS_PER_FRAME(CHANNELS_PER_FRAME),
    .BITS_PER_CHANNEL  (BITS_PER_CHANNEL),
    .OWNED_CHANNELS    (OWNED_CHANNELS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameInN (frameInN),
    .st       (strobes),
    .frameOutN(frameOutN)
  );

  tdm_port_datapath #(
    .WORD_W(WORD_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .rxd      (rxd),
    .txData   (txData),
    .txd      (txd),
    .txOe     (txOe),
    .rxData   (rxData),
    .frameDone(frameDone)
  );

endmodule

// File: tb/sim_tdm_chain_port.sv
`timescale 1ns/1ps
module sim_tdm_chain_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameInN = 1'b1;
  logic        rxd = 1'b1;
  logic [31:0] txData = '0;
  logic        txd, txOe, frameDone, frameOutN;
  logic [31:0] rxData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tdm_chain_port u0 (
    .clk(clk), .rstN(rstN), .frameInN(frameInN), .rxd(rxd),
    .txData(txData), .txd(txd), .txOe(txOe), .rxData(rxData),
    .frameDone(frameDone), .frameOutN(frameOutN)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: act=%h exp=%h", req, $time, act, exp);
    end
  endtask

  function automatic logic expTxd(logic [31:0] tx, int h);
    int c = h / 2;
    return (c < 32) ? tx[31-c] : 1'b1;
  endfunction

  function automatic logic expOe(int h);
    return (h / 2) < 32;
  endfunction

  // h counts falling edges from the frame boundary (h = 0 opens cell 0).
  task automatic runFrame(logic [31:0] curTx, logic [31:0] rx, logic [31:0] prevRx,
                          bit pulseNext, logic [31:0] nextTx, string tag);
    for (int h = 0; h < 512; h++) begin
      @(negedge clk); #2;
      if (h == 0) frameInN = 1'b1;
      if (h % 2 == 0) rxd = (h / 2 < 32) ? rx[31 - h/2] : 1'($urandom);
      if (h == 20) txData = $urandom;
      if (h == 300) txData = nextTx;
      if (h == 511 && pulseNext) frameInN = 1'b0;
      #3;
      if (h == 0) begin
        chk({"R2 cell0 oe ", tag}, {31'd0, txOe}, 32'd1);
        chk({"R7 rxData held ", tag}, rxData, prevRx);
      end
      chk({(h > 20 && h < 64) ? "R4 txd " : ((h < 64) ? "R3 txd " : "R5 txd "), tag},
          {31'd0, txd}, {31'd0, expTxd(curTx, h)});
      chk({"R5 oe ", tag}, {31'd0, txOe}, {31'd0, expOe(h)});
      chk({"R8 frameOutN ", tag}, {31'd0, frameOutN}, {31'd0, (h != 63)});
      chk({"R7 frameDone ", tag}, {31'd0, frameDone}, {31'd0, (h == 64)});
      if (h == 64) chk({"R6 rxData ", tag}, rxData, rx);
    end
  endtask

  task automatic runPartial(int n, logic [31:0] newTx);
    for (int h = 0; h < n; h++) begin
      @(negedge clk); #2;
      if (h == 0) frameInN = 1'b1;
      if (h == 1) txData = newTx;
      rxd = 1'($urandom);
      if (h == n - 1) frameInN = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] curTx, nextTx, rx, prevRx;
    string tag;
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    #2 rstN = 1'b1;
    // R1: idle before any frame pulse, rxd toggling meanwhile.
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #2;
      rxd = 1'($urandom);
      #3;
      chk("R1 txOe", {31'd0, txOe}, 32'd0);
      chk("R1 txd", {31'd0, txd}, 32'd1);
      chk("R1 frameOutN", {31'd0, frameOutN}, 32'd1);
      chk("R1 frameDone", {31'd0, frameDone}, 32'd0);
      chk("R1 rxData", rxData, 32'd0);
    end
    @(negedge clk); #2;
    curTx = 32'h0000_0000;
    txData = curTx;
    frameInN = 1'b0;
    prevRx = '0;
    for (int k = 0; k < 8; k++) begin
      case (k)
        0: begin rx = 32'hFFFF_FFFF; nextTx = 32'hFFFF_FFFF; end
        1: begin rx = 32'h0000_0000; nextTx = 32'hA55A_0FF0; end
        2: begin rx = 32'h8001_7E81; nextTx = $urandom; end
        default: begin rx = $urandom; nextTx = $urandom; end
      endcase
      tag = (k == 5) ? "R9 after missing pulse" : "";
      runFrame(curTx, rx, prevRx, (k != 4), nextTx, tag);
      prevRx = rx;
      curTx = nextTx;
    end
    // R10: short frame of 40 half-cells, then a pulse at a new phase.
    runPartial(40, 32'h3C96_E1D2);
    curTx = 32'h3C96_E1D2;
    for (int k = 0; k < 2; k++) begin
      rx = $urandom;
      nextTx = $urandom;
      runFrame(curTx, rx, prevRx, 1'b1, nextTx, "R10 after resync");
      prevRx = rx;
      curTx = nextTx;
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule